// File: doc/BRIEF.md
# LPC Host SYNC Phase Watchdog

This block sits on the host side of a Low Pin Count bus and watches the four-bit LAD nibble while a peripheral answers in the SYNC phase of a cycle. The surrounding host logic raises a one-clock start strobe in the first SYNC clock. From then on the monitor sorts every nibble into one of five kinds: short wait, long wait, ready, ready-with-error, or invalid. It decides, clock by clock, whether the cycle is still waiting, has finished, or must be abandoned.

Finishing is shown by a ready pulse in the last SYNC clock, which is the clock before the data nibbles. One clock later come a done pulse and an error flag. Abandonment is shown by an abort pulse. Three separate budgets are applied. Invalid nibbles may not run three clocks in a row. Short waits are limited to eight per cycle. Long waits have no limit. A target that switches between the two wait codes inside one cycle is treated as a protocol error. After any outcome the monitor is idle again and can take a new strobe in the very next clock.

Top module: `lpc_sync_watch`

## Requirements
- R1: `ready_pulse` is high in exactly those clocks where a SYNC phase is active and `lad` carries 4'b0000 or 4'b1001. Otherwise it is low.
- R2: A 4'b0000 nibble in an active SYNC phase produces `done` high with `err` low in the following clock, and `abort` stays low.
- R3: A 4'b1001 nibble in an active SYNC phase produces `done` and `err` both high in the following clock.
- R4: A nibble that is not 4'b0000, 4'b0101, 4'b0110 or 4'b1001 is invalid. The third invalid nibble in a row raises `abort` with `err` low one clock later. Any valid nibble restarts this run.
- R5: Up to 8 nibbles of 4'b0101 are accepted in one cycle, whether or not they are consecutive. The ninth raises `abort` with `err` low one clock later.
- R6: Nibbles of 4'b0110 are accepted without any count limit.
- R7: Within one cycle, a 4'b0101 after an earlier 4'b0110, or a 4'b0110 after an earlier 4'b0101, raises `abort` and `err` together one clock later.
- R8: `done` and `abort` are never high together, and each outcome lasts one clock. While idle with no start strobe, `lad` has no effect on any output.
- R9: `sync_start` is ignored while a SYNC phase is already active. It does not restart the budgets.
- R10: While `rst_n` is low, all outputs are low and the monitor is idle.
- R11: The nibble present in the start-strobe clock is judged as the first SYNC nibble. A new cycle may start in the clock right after an outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_start | input | 1 | One-clock strobe marking the first SYNC clock |
| lad | input | 4 | LAD nibble sampled each clock |
| ready_pulse | output | 1 | High in the final SYNC clock, the clock before data |
| done | output | 1 | One-clock pulse: cycle completed |
| err | output | 1 | With `done`: target reported an error. With `abort`: wait codes were mixed |
| abort | output | 1 | One-clock pulse: cycle abandoned |

## Verification
Every clock, the embedded properties check the following:
- a completion nibble is followed by `done`, with the right `err` level;
- `done` and `abort` never occur together;
- an idle clock with no strobe yields no outcome;
- the counters stay inside their budgets;
- the recorded wait kind does not change within a cycle.

Only the bench's scenarios can show the rest: where each budget runs out, that the invalid run restarts after a valid nibble, and that short waits count across interleaved invalid nibbles. The same holds for the immunity to a held start strobe and for back-to-back cycles.

// File: rtl/lpc_sync_pkg.sv
package lpc_sync_pkg;

  localparam logic [3:0] CODE_READY = 4'b0000;
  localparam logic [3:0] CODE_SHORT = 4'b0101;
  localparam logic [3:0] CODE_LONG  = 4'b0110;
  localparam logic [3:0] CODE_FAULT = 4'b1001;

  typedef enum logic [2:0] {
    NIB_SHORT,
    NIB_LONG,
    NIB_OK,
    NIB_ERR,
    NIB_BAD
  } nib_cls_e;

  typedef enum logic [1:0] {
    WK_NONE,
    WK_SHORT,
    WK_LONG
  } wait_kind_e;

  typedef enum logic {
    ST_IDLE,
    ST_SYNC
  } mon_state_e;

endpackage

// File: rtl/lpc_sync_decode.sv
module lpc_sync_decode
  import lpc_sync_pkg::*;
(
  input  logic [3:0] lad,
  output nib_cls_e   cls
);

  always_comb begin
    case (lad)
      CODE_SHORT: cls = NIB_SHORT;
      CODE_LONG:  cls = NIB_LONG;
      CODE_READY: cls = NIB_OK;
      CODE_FAULT: cls = NIB_ERR;
      default:    cls = NIB_BAD;
    endcase
  end

endmodule

// File: rtl/lpc_sync_limits.sv
module lpc_sync_limits
  import lpc_sync_pkg::*;
#(
  parameter int BAD_LIMIT = 3,
  parameter int SHORT_MAX = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     step,
  input  logic     fresh,
  input  nib_cls_e cls,
  output logic     bad_hit,
  output logic     short_hit,
  output logic     mix_hit
);

  localparam int BW = (BAD_LIMIT > 2) ? $clog2(BAD_LIMIT) : 1;
  localparam int SW = $clog2(SHORT_MAX + 1);
  localparam logic [BW-1:0] BAD_TOP   = BW'(BAD_LIMIT - 1);
  localparam logic [SW-1:0] SHORT_TOP = SW'(SHORT_MAX);

  logic [BW-1:0] bad_q, bad_eff, bad_d;
  logic [SW-1:0] short_q, short_eff, short_d;
  wait_kind_e    kind_q, kind_eff, kind_d;

  // a fresh cycle sees empty budgets regardless of leftovers
  always_comb begin
    bad_eff   = fresh ? '0 : bad_q;
    short_eff = fresh ? '0 : short_q;
    kind_eff  = fresh ? WK_NONE : kind_q;
  end

  always_comb begin
    bad_hit   = (cls == NIB_BAD) && (bad_eff == BAD_TOP);
    short_hit = (cls == NIB_SHORT) && (short_eff == SHORT_TOP);
    mix_hit   = ((cls == NIB_SHORT) && (kind_eff == WK_LONG)) ||
                ((cls == NIB_LONG)  && (kind_eff == WK_SHORT));
  end

  always_comb begin
    bad_d   = (cls == NIB_BAD) ? bad_eff + 1'b1 : '0;
    short_d = (cls == NIB_SHORT) ? short_eff + 1'b1 : short_eff;
    kind_d  = kind_eff;
    if (kind_eff == WK_NONE) begin
      if (cls == NIB_SHORT)     kind_d = WK_SHORT;
      else if (cls == NIB_LONG) kind_d = WK_LONG;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bad_q   <= '0;
      short_q <= '0;
      kind_q  <= WK_NONE;
    end else if (step && !bad_hit && !short_hit) begin
      bad_q   <= bad_d;
      short_q <= short_d;
      kind_q  <= kind_d;
    end
  end

  p_bad_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bad_q <= BAD_TOP);

  p_short_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    short_q <= SHORT_TOP);

  p_kind_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !fresh && kind_q != WK_NONE) |=> (kind_q == $past(kind_q)));

endmodule

// File: rtl/lpc_sync_watch.sv
module lpc_sync_watch
  import lpc_sync_pkg::*;
#(
  parameter int BAD_LIMIT = 3,
  parameter int SHORT_MAX = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_start,
  input  logic [3:0] lad,
  output logic       ready_pulse,
  output logic       done,
  output logic       err,
  output logic       abort
);

  mon_state_e st_q, st_d;
  nib_cls_e   cls;
  logic       fresh, active;
  logic       bad_hit, short_hit, mix_hit;
  logic       fin_ok, fin_err, kill;
  logic       done_d, err_d, abort_d;

  assign fresh  = (st_q == ST_IDLE) && sync_start;
  assign active = (st_q == ST_SYNC) || fresh;

  lpc_sync_decode u_dec (
    .lad (lad),
    .cls (cls)
  );

  lpc_sync_limits #(
    .BAD_LIMIT (BAD_LIMIT),
    .SHORT_MAX (SHORT_MAX)
  ) u_lim (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (active),
    .fresh     (fresh),
    .cls       (cls),
    .bad_hit   (bad_hit),
    .short_hit (short_hit),
    .mix_hit   (mix_hit)
  );

  always_comb begin
    fin_ok  = active && (cls == NIB_OK);
    fin_err = active && (cls == NIB_ERR);
    kill    = active && (bad_hit || short_hit || mix_hit);
    done_d  = fin_ok || fin_err;
    err_d   = fin_err || (active && mix_hit);
    abort_d = kill;
    if (done_d || kill) st_d = ST_IDLE;
    else if (active)    st_d = ST_SYNC;
    else                st_d = ST_IDLE;
  end

  assign ready_pulse = fin_ok || fin_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      done  <= 1'b0;
      err   <= 1'b0;
      abort <= 1'b0;
    end else begin
      st_q  <= st_d;
      done  <= done_d;
      err   <= err_d;
      abort <= abort_d;
    end
  end

  p_ready_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ready_pulse |=> done);

  p_ok_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && lad == 4'b0000) |=> (done && !err && !abort));

  p_fault_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && lad == 4'b1001) |=> (done && err));

  p_err_context_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (done || abort));

  p_outcome_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && abort));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !sync_start) |=> (!done && !abort && !err));

endmodule

// File: tb/lpc_sync_watch_test.sv
module lpc_sync_watch_test;

  localparam int HALF = 10;
  localparam int NV   = 14;

  // {len[7:0], outcome[3:0], pad[3:0], nibbles[63:0]}, first nibble in the top bits
  // outcome: 1 done ok, 2 done err, 3 abort, 4 abort with err
  localparam logic [79:0] VEC [NV] = '{
    {8'd1,  4'd1, 4'h0, 64'h0000_0000_0000_0000},
    {8'd1,  4'd2, 4'h0, 64'h9000_0000_0000_0000},
    {8'd3,  4'd1, 4'h0, 64'h5500_0000_0000_0000},
    {8'd11, 4'd2, 4'h0, 64'h6666_6666_6690_0000},
    {8'd9,  4'd1, 4'h0, 64'h5555_5555_0000_0000},
    {8'd9,  4'd3, 4'h0, 64'h5555_5555_5000_0000},
    {8'd3,  4'd3, 4'h0, 64'hFFF0_0000_0000_0000},
    {8'd6,  4'd1, 4'h0, 64'hFF5F_F000_0000_0000},
    {8'd2,  4'd4, 4'h0, 64'h5600_0000_0000_0000},
    {8'd2,  4'd4, 4'h0, 64'h6500_0000_0000_0000},
    {8'd6,  4'd2, 4'h0, 64'h6FF6_F900_0000_0000},
    {8'd3,  4'd3, 4'h0, 64'h1230_0000_0000_0000},
    {8'd16, 4'd3, 4'h0, 64'h5F5F_5F5F_5F5F_5F55},
    {8'd4,  4'd1, 4'h0, 64'h6FF0_0000_0000_0000}
  };

  logic       clk;
  logic       rst_n;
  logic       sync_start;
  logic [3:0] lad;
  logic       ready_pulse, done, err, abort;

  int checks = 0;
  int fails  = 0;

  lpc_sync_watch uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_start  (sync_start),
    .lad         (lad),
    .ready_pulse (ready_pulse),
    .done        (done),
    .err         (err),
    .abort       (abort)
  );

  initial clk = 1'b0;
  always #HALF clk = ~clk;

  task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got {rdy,done,err,abort}=%b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [3:0] outs();
    return {ready_pulse, done, err, abort};
  endfunction

  function automatic logic [3:0] outcome_bits(input int code);
    case (code)
      1: return 4'b0100;
      2: return 4'b0110;
      3: return 4'b0001;
      4: return 4'b0011;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic drive(input logic s, input logic [3:0] n);
    @(negedge clk);
    sync_start = s;
    lad        = n;
    #1;
  endtask

  initial begin
    #(2 * HALF * 200000);
    fails++;
    $display("FAIL watchdog: got no finish expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    sync_start = 1'b0;
    lad = 4'h0;
    #3;
    check("R10 reset outputs", outs(), 4'b0000);
    repeat (2) @(negedge clk);
    check("R10 held reset", outs(), 4'b0000);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      int len;
      int oc;
      len = int'(VEC[v][79:72]);
      oc  = int'(VEC[v][71:68]);
      for (int i = 0; i < len; i++) begin
        logic [3:0] nib;
        logic       last_rdy;
        nib = VEC[v][63 - 4*i -: 4];
        drive(i == 0, nib);
        last_rdy = (i == len - 1) && (oc == 1 || oc == 2);
        // R1: ready flag in SYNC clock; R11: first nibble taken with strobe
        check("R1/R11 in-phase", outs(), {last_rdy, 3'b000});
      end
      drive(1'b0, 4'h0);
      case (oc)
        1: check("R2 R5 R6 R4 outcome", outs(), outcome_bits(oc));
        2: check("R3 R6 outcome", outs(), outcome_bits(oc));
        3: check("R4 R5 outcome", outs(), outcome_bits(oc));
        default: check("R7 outcome", outs(), outcome_bits(oc));
      endcase
      drive(1'b0, 4'h0);
      check("R8 single pulse idle", outs(), 4'b0000);
    end

    // R8: idle lad activity is ignored
    drive(1'b0, 4'h9);
    check("R8 idle lad 1001", outs(), 4'b0000);
    drive(1'b0, 4'h0);
    check("R8 idle lad 0000", outs(), 4'b0000);
    drive(1'b0, 4'h0);
    check("R8 idle no outcome", outs(), 4'b0000);

    // R9: strobe held through nine short waits must not refresh budget
    for (int i = 0; i < 9; i++) begin
      drive(1'b1, 4'h5);
      check("R9 held strobe wait", outs(), 4'b0000);
    end
    drive(1'b0, 4'h0);
    check("R9 abort despite strobe", outs(), 4'b0001);

    // R11: back-to-back one-clock cycles
    drive(1'b1, 4'h0);
    check("R11 first quick ready", outs(), 4'b1000);
    drive(1'b1, 4'h9);
    check("R11 second start after done", outs(), 4'b1100);
    drive(1'b0, 4'h0);
    check("R11 second outcome", outs(), 4'b0110);

    // R10: reset mid-cycle returns to idle
    drive(1'b1, 4'h5);
    drive(1'b0, 4'h5);
    rst_n = 1'b0;
    #1;
    check("R10 async reset", outs(), 4'b0000);
    drive(1'b0, 4'h0);
    rst_n = 1'b1;
    drive(1'b0, 4'h0);
    check("R10 idle after reset", outs(), 4'b0000);
    drive(1'b0, 4'h0);
    check("R10 no stale done", outs(), 4'b0000);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule